// File: doc/BRIEF.md
# ADC serial command and data port

This block is the serial slave port of a successive-approximation converter. A host talks to it over a four-wire serial link whose clock idles high; the host changes SDI after a falling SCLK edge and the port samples SDI on the next falling edge. The port launches its own SDO bits the same way. Each frame starts when chip select falls. The first four received bits are an opcode. Short opcodes act on the fourth falling edge: channel select, wake-up, load defaults, and the reserved codes. A configuration write carries twelve more bits and acts on the sixteenth falling edge. The link is full duplex, so while an opcode arrives, SDO is already shifting out the latest conversion result.

The sequencer supplies a result word and a 3-bit channel tag together with an end-of-conversion strobe. The port holds them in an output register and takes a snapshot at the falling edge of chip select. Two configuration bits change the frame. The tag-enable bit appends the channel tag after the LSB. The chain bit turns the port into a stage of a daisy chain: after the local word it forwards bits received on a chain input, delayed by 16 or 24 falling edges. SCLK, chip select, SDI and the chain input are all synchronized into the system clock, which must run at least four times faster than SCLK.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the configuration output reads 0xFFF, SDO is not driven (sdo_oe_o low), the channel output is 0 and the error flag is clear.
- R2: sdo_oe_o is high exactly while a frame is open, from the chip-select fall to its rise. The first SDO bit, visible before the first falling SCLK edge, is the MSB of the snapshot word.
- R3: Opcode values 0 to NUM_CH-1 set the channel output on the fourth falling edge and pulse chan_stb_o. Values from NUM_CH to 7 leave the channel unchanged and set the error flag.
- R4: Opcode 0xE followed by a 12-bit value, MSB first, loads the configuration on the sixteenth falling edge. Up to the fifteenth edge the configuration is unchanged.
- R5: Opcode 0xC shifts out the top 4 bits of the held result, then the 12 configuration bits MSB first.
- R6: Opcode 0xF sets every configuration bit to 1.
- R7: Opcode 0xB sets configuration bits 3 and 2 to 1, leaves the other bits alone, and pulses wake_stb_o.
- R8: Opcodes 0x8, 0x9 and 0xA change neither the configuration nor the channel. They set the error flag, which stays set until a reset or a software reset.
- R9: A configuration write whose bit 0 is 0 is a software reset. Configuration returns to 0xFFF, the channel to 0 and the error flag to clear, and the next frame is treated as the first after reset.
- R10: With configuration bit 1 = 1, the 3 tag bits follow the 16 data bits. With bit 1 = 0 they do not. In both cases every later bit is 0 until chip select rises.
- R11: With configuration bit 5 = 0 (chain mode), each chain-input bit sampled on a falling edge reappears on SDO 16 falling edges later with tags off, or 24 with tags on. It therefore follows the 16- or 24-bit local word.
- R12: The first frame after any reset shifts out only ones.
- R13: A new result that arrives while a frame is open does not alter that frame. It appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles high, asynchronous |
| sdi_i | input | 1 | Serial data from host |
| chain_i | input | 1 | Serial data from an upstream converter |
| conv_done_i | input | 1 | End-of-conversion strobe from sequencer |
| conv_data_i | input | 16 | Conversion result |
| conv_tag_i | input | 3 | Channel that produced the result |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for SDO (tri-state control) |
| cfg_o | output | 12 | Configuration register |
| chan_o | output | $clog2(NUM_CH) | Selected channel |
| chan_stb_o | output | 1 | One-cycle pulse when a channel is selected |
| wake_stb_o | output | 1 | One-cycle pulse on wake-up opcode |
| cmd_err_o | output | 1 | Sticky flag for a rejected opcode |

## Verification
The bench builds the port with NUM_CH = 4 and two synchronizer stages. With four channels, codes 4 to 7 are valid opcodes that must be rejected, so the out-of-range branch of channel selection is exercised. SCLK runs at one twelfth of the system clock, which leaves room to probe the configuration output between the fifteenth and sixteenth falling edges. Frames of up to 48 bits reach past both chain delays and the zero padding.

// File: rtl/adcp_pkg.sv
package adcp_pkg;
    localparam int CMD_W   = 4;
    localparam int CFG_W   = 12;
    localparam int DATA_W  = 16;
    localparam int TAG_W   = 3;
    localparam int FRAME_W = DATA_W + TAG_W + 5;
    localparam int CNT_W   = 5;
    localparam int RX_W    = CFG_W - 1;

    localparam logic [CMD_W-1:0] OP_WAKE     = 4'hB;
    localparam logic [CMD_W-1:0] OP_CFG_RD   = 4'hC;
    localparam logic [CMD_W-1:0] OP_CFG_WR   = 4'hE;
    localparam logic [CMD_W-1:0] OP_DEFAULTS = 4'hF;

    localparam int BIT_SRST  = 0;
    localparam int BIT_TAG   = 1;
    localparam int BIT_DEEP  = 2;
    localparam int BIT_NAP   = 3;
    localparam int BIT_CHAIN = 5;

    localparam logic [CFG_W-1:0] CFG_DEFAULT = '1;

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [RX_W-1:0]   rx;
        logic [CMD_W-1:0]  cmd;
        logic              sclk_prev;
        logic              cs_prev;
    } port_t;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0]  data;
        logic [TAG_W-1:0]   tag;
        logic               ones_pend;
        logic               ones_frame;
    } tx_t;
endpackage

// File: rtl/adcp_sync.sv
module adcp_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adcp_cfg.sv
module adcp_cfg
    import adcp_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             wr_stb_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             chan_stb_o,
    output logic             wake_stb_o,
    output logic             err_o,
    output logic             srst_o
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [CH_W-1:0]  chan;
        logic             chan_stb;
        logic             wake;
        logic             err;
        logic             srst;
    } cfg_t;

    cfg_t d, q;

    always_comb begin
        d          = q;
        d.chan_stb = 1'b0;
        d.wake     = 1'b0;
        d.srst     = 1'b0;
        if (cmd_stb_i) begin
            if (!cmd_i[CMD_W-1]) begin
                if (32'(cmd_i[2:0]) < NUM_CH) begin
                    d.chan     = cmd_i[CH_W-1:0];
                    d.chan_stb = 1'b1;
                end else begin
                    d.err = 1'b1;
                end
            end else if (cmd_i == OP_WAKE) begin
                d.cfg[BIT_NAP]  = 1'b1;
                d.cfg[BIT_DEEP] = 1'b1;
                d.wake          = 1'b1;
            end else if (cmd_i == OP_DEFAULTS) begin
                d.cfg = CFG_DEFAULT;
            end else if (cmd_i < OP_WAKE) begin
                d.err = 1'b1;
            end
        end
        if (wr_stb_i) begin
            if (!wr_data_i[BIT_SRST]) begin
                d.cfg  = CFG_DEFAULT;
                d.chan = '0;
                d.err  = 1'b0;
                d.srst = 1'b1;
            end else begin
                d.cfg = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.cfg <= CFG_DEFAULT;
        end else begin
            q <= d;
        end
    end

    assign cfg_o      = q.cfg;
    assign chan_o     = q.chan;
    assign chan_stb_o = q.chan_stb;
    assign wake_stb_o = q.wake;
    assign err_o      = q.err;
    assign srst_o     = q.srst;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !(wr_stb_i && !wr_data_i[BIT_SRST])) |=> q.err);
    // R3
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(q.chan) < NUM_CH);
    // R7
    wake_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wake |-> (q.cfg[BIT_NAP] && q.cfg[BIT_DEEP]));
    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_stb_i && !wr_stb_i) |=> $stable(q.cfg));
endmodule

// File: rtl/adcp_tx.sv
module adcp_tx
    import adcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              srst_i,
    input  logic              start_i,
    input  logic              shift_i,
    input  logic              din_i,
    input  logic              cfg_rd_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              tag_en_i,
    input  logic              chain_en_i,
    output logic              bit_o,
    output logic              ones_o
);
    localparam int INS_NOTAG = FRAME_W - DATA_W;
    localparam int CFG_LO    = FRAME_W - CFG_W;

    tx_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.data = data_i;
            d.tag  = tag_i;
        end
        if (srst_i) d.ones_pend = 1'b1;
        if (start_i) begin
            if (q.ones_pend) begin
                d.sh         = '1;
                d.ones_frame = 1'b1;
                d.ones_pend  = 1'b0;
            end else begin
                d.sh         = {q.data, (tag_en_i ? q.tag : {TAG_W{1'b0}}), 5'b0};
                d.ones_frame = 1'b0;
            end
        end else if (shift_i) begin
            d.sh = {q.sh[FRAME_W-2:0], q.ones_frame};
            if (!q.ones_frame && chain_en_i) begin
                if (tag_en_i) d.sh[0]         = din_i;
                else          d.sh[INS_NOTAG] = din_i;
            end
            if (cfg_rd_i && !q.ones_frame) begin
                d.sh[FRAME_W-1:CFG_LO] = cfg_i;
                if (!chain_en_i) d.sh[CFG_LO-1:0] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.ones_pend <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign bit_o  = q.sh[FRAME_W-1];
    assign ones_o = q.ones_frame;

    // R13
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !shift_i) |=> $stable(q.sh));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adcp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CH      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n_i,
    input  logic                      sclk_i,
    input  logic                      sdi_i,
    input  logic                      chain_i,
    input  logic                      conv_done_i,
    input  logic [15:0]               conv_data_i,
    input  logic [2:0]                conv_tag_i,
    output logic                      sdo_o,
    output logic                      sdo_oe_o,
    output logic [11:0]               cfg_o,
    output logic [$clog2(NUM_CH)-1:0] chan_o,
    output logic                      chan_stb_o,
    output logic                      wake_stb_o,
    output logic                      cmd_err_o
);
    localparam int N_SYNC = 4;
    localparam logic [N_SYNC-1:0] SYNC_IDLE = 4'b0011;

    logic [N_SYNC-1:0] raw, synced;
    logic sclk_s, cs_s, sdi_s, chain_s;

    assign raw = {chain_i, sdi_i, cs_n_i, sclk_i};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        adcp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE[g])) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw[g]),
            .q_o   (synced[g])
        );
    end

    assign sclk_s  = synced[0];
    assign cs_s    = synced[1];
    assign sdi_s   = synced[2];
    assign chain_s = synced[3];

    port_t d, q;
    logic cs_fall, cs_rise, sclk_fall;
    logic cmd_stb, wr_stb, cfg_rd;
    logic [CMD_W-1:0] cmd_now;
    logic [CFG_W-1:0] wr_word;
    logic [CFG_W-1:0] cfg;
    logic srst, tx_bit, ones_frame;

    assign cs_fall   = q.cs_prev & ~cs_s;
    assign cs_rise   = ~q.cs_prev & cs_s;
    assign sclk_fall = q.sclk_prev & ~sclk_s & q.active & ~cs_fall & ~cs_rise;
    assign cmd_now   = {q.rx[2:0], sdi_s};
    assign wr_word   = {q.rx, sdi_s};

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        d.cs_prev   = cs_s;
        cmd_stb     = 1'b0;
        wr_stb      = 1'b0;
        cfg_rd      = 1'b0;
        if (cs_fall) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.rx     = '0;
            d.cmd    = '0;
        end else if (cs_rise) begin
            d.active = 1'b0;
        end else if (sclk_fall) begin
            d.rx = {q.rx[RX_W-2:0], sdi_s};
            if (q.cnt != '1) d.cnt = q.cnt + CNT_W'(1);
            if (q.cnt == CNT_W'(CMD_W - 1)) begin
                cmd_stb = 1'b1;
                d.cmd   = cmd_now;
                cfg_rd  = (cmd_now == OP_CFG_RD);
            end
            if (q.cnt == CNT_W'(CMD_W + CFG_W - 1) && q.cmd == OP_CFG_WR) begin
                wr_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.sclk_prev <= 1'b1;
            q.cs_prev   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    adcp_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb_i  (cmd_stb),
        .cmd_i      (cmd_now),
        .wr_stb_i   (wr_stb),
        .wr_data_i  (wr_word),
        .cfg_o      (cfg),
        .chan_o     (chan_o),
        .chan_stb_o (chan_stb_o),
        .wake_stb_o (wake_stb_o),
        .err_o      (cmd_err_o),
        .srst_o     (srst)
    );

    adcp_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (conv_done_i),
        .data_i     (conv_data_i),
        .tag_i      (conv_tag_i),
        .srst_i     (srst),
        .start_i    (cs_fall),
        .shift_i    (sclk_fall),
        .din_i      (chain_s),
        .cfg_rd_i   (cfg_rd),
        .cfg_i      (cfg),
        .tag_en_i   (cfg[BIT_TAG]),
        .chain_en_i (~cfg[BIT_CHAIN]),
        .bit_o      (tx_bit),
        .ones_o     (ones_frame)
    );

    assign cfg_o    = cfg;
    assign sdo_oe_o = q.active;
    assign sdo_o    = q.active & tx_bit;

    // R2
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_oe_o);
    // R10
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.cnt >= CNT_W'(FRAME_W) && cfg[BIT_CHAIN] && !ones_frame) |-> !sdo_o);
    // R12
    ones_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && ones_frame) |-> sdo_o);
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && q.cnt != '1) |=> q.cnt == $past(q.cnt) + CNT_W'(1));
endmodule

// File: tb/tb_adc_serial_port.sv
`timescale 1ns/1ps
module tb_adc_serial_port;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, chain = 1'b0;
    logic conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic [2:0]  conv_tag = '0;
    logic sdo, sdo_oe, chan_stb, wake_stb, cmd_err;
    logic [11:0] cfg;
    logic [1:0]  chan;

    int n_chk = 0, n_bad = 0, wake_cnt = 0;

    always #2.5 clk = ~clk;

    adc_serial_port #(.SYNC_STAGES(2), .NUM_CH(4)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .chain_i(chain), .conv_done_i(conv_done), .conv_data_i(conv_data),
        .conv_tag_i(conv_tag), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg),
        .chan_o(chan), .chan_stb_o(chan_stb), .wake_stb_o(wake_stb),
        .cmd_err_o(cmd_err)
    );

    always @(posedge clk) if (rst_n && wake_stb) wake_cnt++;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_result(input logic [15:0] v, input logic [2:0] t);
        tick(1);
        conv_data = v; conv_tag = t; conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
    endtask

    function automatic logic [47:0] word(input logic [3:0] op, input logic [11:0] v);
        return {op, v, 32'h0};
    endfunction

    task automatic xfer(input logic [47:0] tx, input int n, input logic [47:0] chn,
                        input int probe_n, input bit mid_load,
                        output logic [47:0] rx, output logic [11:0] probe, output bit oe_ok);
        rx = '0; probe = '0; oe_ok = 1'b1;
        tick(1);
        cs_n = 1'b0;
        tick(HALF);
        if (mid_load) load_result(16'h0F0F, 3'd2);
        for (int i = 0; i < n; i++) begin
            sdi = tx[47-i]; chain = chn[47-i];
            tick(HALF);
            rx[47-i] = sdo;
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
            sclk = 1'b0;
            tick(HALF);
            if (i + 1 == probe_n) probe = cfg;
            sclk = 1'b1;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
    endtask

    logic [47:0] rx;
    logic [11:0] pr;
    bit oe;

    task automatic t_reset();
        chk("R1 cfg", 48'(cfg), 48'hFFF);
        chk("R1 oe", 48'(sdo_oe), 48'h0);
        chk("R1 chan", 48'(chan), 48'h0);
        chk("R1 err", 48'(cmd_err), 48'h0);
    endtask

    task automatic t_first_frame();
        load_result(16'hA5C3, 3'd5);
        xfer(word(4'hD, 12'h0), 24, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R12 ones frame", rx, {24'hFFFFFF, 24'h0});
        chk("R2 oe in frame", 48'(oe), 48'h1);
        chk("R2 oe after frame", 48'(sdo_oe), 48'h0);
    endtask

    task automatic t_read_data();
        xfer(word(4'hD, 12'h0), 24, 48'h0, 0, 1'b1, rx, pr, oe);
        chk("R13 R10 snapshot with tag", rx, {16'hA5C3, 3'd5, 5'd0, 24'h0});
        xfer(word(4'hD, 12'h0), 24, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R13 new result next frame", rx, {16'h0F0F, 3'd2, 5'd0, 24'h0});
    endtask

    task automatic t_channel();
        xfer(word(4'h2, 12'h0), 4, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R3 chan select", 48'(chan), 48'h2);
        chk("R3 no err", 48'(cmd_err), 48'h0);
        xfer(word(4'h9, 12'h0), 4, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R8 reserved cfg", 48'(cfg), 48'hFFF);
        chk("R8 reserved chan", 48'(chan), 48'h2);
        chk("R8 reserved err", 48'(cmd_err), 48'h1);
        xfer(word(4'h5, 12'h0), 4, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R3 out of range chan", 48'(chan), 48'h2);
    endtask

    task automatic t_cfg_write_read();
        xfer(word(4'hE, 12'h7F3), 16, 48'h0, 15, 1'b0, rx, pr, oe);
        chk("R4 cfg before 16th", 48'(pr), 48'hFFF);
        chk("R4 cfg after", 48'(cfg), 48'h7F3);
        xfer(word(4'hC, 12'h0), 16, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R5 cfg read", rx, {16'h07F3, 32'h0});
    endtask

    task automatic t_wake_default();
        xfer(word(4'hB, 12'h0), 4, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R7 wake cfg", 48'(cfg), 48'h7FF);
        chk("R7 wake pulse", 48'(wake_cnt), 48'h1);
        xfer(word(4'hE, 12'h5D1), 16, 48'h0, 0, 1'b0, rx, pr, oe);
        xfer(word(4'hF, 12'h0), 4, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R6 defaults", 48'(cfg), 48'hFFF);
    endtask

    task automatic t_tag_off();
        xfer(word(4'hE, 12'hFFD), 16, 48'h0, 0, 1'b0, rx, pr, oe);
        xfer(word(4'hD, 12'h0), 24, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R10 tag off", rx, {16'h0F0F, 32'h0});
    endtask

    task automatic t_chain();
        xfer(word(4'hE, 12'hFDD), 16, 48'h0, 0, 1'b0, rx, pr, oe);
        xfer(word(4'hD, 12'h0), 32, 48'hC3A5_0000_0000, 0, 1'b0, rx, pr, oe);
        chk("R11 chain delay 16", rx, {16'h0F0F, 16'hC3A5, 16'h0});
        xfer(word(4'hE, 12'hFDF), 16, 48'h0, 0, 1'b0, rx, pr, oe);
        xfer(word(4'hD, 12'h0), 48, 48'h9E4B_71C2_A5F0, 0, 1'b0, rx, pr, oe);
        chk("R11 chain delay 24", rx, {16'h0F0F, 3'd2, 5'd0, 24'h9E4B71});
    endtask

    task automatic t_soft_reset();
        chk("R8 err still set", 48'(cmd_err), 48'h1);
        xfer(word(4'hE, 12'h5D0), 16, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R9 cfg", 48'(cfg), 48'hFFF);
        chk("R9 err", 48'(cmd_err), 48'h0);
        chk("R9 chan", 48'(chan), 48'h0);
        xfer(word(4'hD, 12'h0), 24, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R9 R12 ones after soft reset", rx, {24'hFFFFFF, 24'h0});
        xfer(word(4'hD, 12'h0), 32, 48'h0, 0, 1'b0, rx, pr, oe);
        chk("R10 zero padding", rx, {16'h0F0F, 3'd2, 5'd0, 8'h00, 16'h0});
    endtask

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_first_frame();
        t_read_data();
        t_channel();
        t_cfg_write_read();
        t_wake_default();
        t_tag_off();
        t_chain();
        t_soft_reset();
        summary();
        $finish;
    end
endmodule